// File: doc/BRIEF.md
# Nibble-Polarity Event Sense Interrupt Unit

This block watches a bank of already-conditioned digital input levels for edges and turns the edges it is told to care about into latched per-channel status and an active-low interrupt request. The direction of edge that counts is chosen per group of four channels. Whether a channel is watched at all is chosen per channel. A host reaches all settings and the status through a simple byte-wide register port. Writes take effect on the clock edge. Reads are combinational on the address.

Each detected edge sets a status bit that stays set until the host writes a one to it. While that bit is set, the channel cannot raise a fresh interrupt. A summary byte shows which 8-channel ports hold pending status, plus a global pending flag.

A control byte holds the global interrupt enable and a self-clearing soft-reset command. The soft reset returns the event configuration and status to their defaults but leaves the interrupt enable as it was. A debouncer may sit upstream, so that only filtered edges arrive. Change-of-state sensing is built by wiring one signal into two channels in different groups and giving those groups opposite polarity.

Top module: `evs_unit`

## Requirements
- R1: An enabled channel in a positive group sets its status bit at the first clock edge where the new high level meets a low level held from the previous cycle. The bit is readable right after that edge.
- R2: The polarity register at address 4 holds one bit per group. Bit g covers channels 4g to 4g+3. A 0 selects low-to-high edges and a 1 selects high-to-low edges. The register reads back what was written.
- R3: After power-up reset, and after a soft reset, every channel enable (addresses 0 to 3, byte k covering channels 8k to 8k+7), every polarity bit and every status bit reads 0. A channel that was enabled before a soft reset no longer latches edges after it.
- R4: The interrupt output irq_n is low exactly when bit 0 of the control register (address 10) is 1 and at least one status bit is set. With bit 0 at 0, status still latches and irq_n stays high.
- R5: An edge on a channel whose enable bit is 0 leaves all status unchanged.
- R6: Status bytes sit at addresses 5 to 8, byte k covering channels 8k to 8k+7. Writing 1 to a bit clears it. Writing 0 leaves it as it was.
- R7: A clear write and a new event on the same channel in the same cycle leave the status bit set.
- R8: Writing the control register with bit 1 set performs a soft reset and leaves the interrupt enable bit unchanged. Writing with bit 1 clear loads bit 0 into the enable. Power-up reset clears the enable.
- R9: The summary register at address 11-2=9 reads bit k set when any status bit of port k is set. Bit 7 is set when any status bit at all is set. All other bits read 0.
- R10: One signal wired to a channel in a positive group and to a channel in a negative group latches status on the first channel for its rise and on the second for its fall.
- R11: A level that stays constant produces no event. Once a cleared channel has no new transition, it stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up / bus reset |
| in_lvl | input | NUM_CH | Conditioned input levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An input change driven between clock edges is seen at the next rising edge. There it meets the previous-cycle copy and sets status at once. The bench therefore reads status, summary and irq_n at the falling edge one cycle after the change. A register write is applied at the rising edge inside its strobe, and its effect is read at the following falling edge, since reads need no cycle. The same-cycle clear-and-event case drives both in one half period so that they land on the same edge.

// File: rtl/evs_pkg.sv
package evs_pkg;
   localparam int BYTE_W    = 8;
   localparam int SUM_FLAG  = 7;
   localparam int CTL_IEN   = 0;
   localparam int CTL_SRST  = 1;
endpackage

// File: rtl/evs_edge_detect.sv
module evs_edge_detect
   import evs_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int GROUP_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         in_lvl,
   input  logic [NUM_CH/GROUP_W-1:0] pol,
   input  logic [NUM_CH-1:0]         en,
   output logic [NUM_CH-1:0]         hit
);
   localparam int NUM_GROUPS = NUM_CH / GROUP_W;

   if (NUM_CH % GROUP_W != 0) begin : g_bad_group
      $error("NUM_CH must be a multiple of GROUP_W");
   end

   logic [NUM_CH-1:0] prev_q;
   logic [NUM_CH-1:0] raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= in_lvl;
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [GROUP_W-1:0] cur, old;
      assign cur = in_lvl[g*GROUP_W +: GROUP_W];
      assign old = prev_q[g*GROUP_W +: GROUP_W];
      assign raw[g*GROUP_W +: GROUP_W] = pol[g] ? (old & ~cur) : (cur & ~old);
   end

   assign hit = raw & en;
endmodule

// File: rtl/evs_status_latch.sv
module evs_status_latch #(
   parameter int NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic [NUM_CH-1:0] set,
   input  logic [NUM_CH-1:0] clr,
   input  logic [NUM_CH-1:0] en,
   output logic [NUM_CH-1:0] stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stat <= '0;
      else if (srst) stat <= '0;
      else           stat <= (stat & ~clr) | set;
   end

   // R6: a set bit is only removed by a clear write or a soft reset
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !srst |=> ((($past(stat) & ~$past(clr)) & ~stat) == '0));

   // R5: newly set bits come only from enabled channels
   assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !srst |=> ((stat & ~$past(stat) & ~$past(en)) == '0));
endmodule

// File: rtl/evs_port_summary.sv
module evs_port_summary
   import evs_pkg::*;
#(
   parameter int NUM_CH = 32
) (
   input  logic [NUM_CH-1:0] stat,
   output logic [BYTE_W-1:0] summary
);
   localparam int NUM_PORTS = NUM_CH / BYTE_W;

   if (NUM_PORTS > SUM_FLAG) begin : g_bad_ports
      $error("too many ports for the summary byte");
   end

   always_comb begin
      summary = '0;
      for (int k = 0; k < NUM_PORTS; k++)
         summary[k] = |stat[k*BYTE_W +: BYTE_W];
      summary[SUM_FLAG] = |stat;
   end
endmodule

// File: rtl/evs_unit.sv
module evs_unit
   import evs_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int GROUP_W = 4,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] in_lvl,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic              irq_n
);
   localparam int NUM_PORTS  = NUM_CH / BYTE_W;
   localparam int NUM_GROUPS = NUM_CH / GROUP_W;
   localparam int POL_REGS   = NUM_GROUPS / BYTE_W;
   localparam int EN_BASE    = 0;
   localparam int POL_BASE   = EN_BASE + NUM_PORTS;
   localparam int STAT_BASE  = POL_BASE + POL_REGS;
   localparam int SUM_ADDR   = STAT_BASE + NUM_PORTS;
   localparam int CTL_ADDR   = SUM_ADDR + 1;

   if (NUM_CH % BYTE_W != 0) begin : g_bad_ch
      $error("NUM_CH must be a multiple of 8");
   end
   if (BYTE_W % GROUP_W != 0) begin : g_bad_gw
      $error("GROUP_W must divide 8");
   end
   if (NUM_GROUPS % BYTE_W != 0) begin : g_bad_pol
      $error("group count must fill whole polarity bytes");
   end
   if (CTL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_CH-1:0]     en_q;
   logic [NUM_GROUPS-1:0] pol_q;
   logic                  ien_q;
   logic [NUM_CH-1:0]     clr;
   logic [NUM_CH-1:0]     hit;
   logic [NUM_CH-1:0]     stat;
   logic [BYTE_W-1:0]     summary;
   logic                  ctl_wr;
   logic                  srst;

   assign ctl_wr = wr_en && (addr == ADDR_W'(CTL_ADDR));
   assign srst   = ctl_wr && wr_data[CTL_SRST];

   always_comb begin
      clr = '0;
      for (int k = 0; k < NUM_PORTS; k++)
         if (wr_en && addr == ADDR_W'(STAT_BASE + k))
            clr[k*BYTE_W +: BYTE_W] = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= '0;
         ien_q <= 1'b0;
      end else if (srst) begin
         en_q  <= '0;
         pol_q <= '0;
      end else begin
         for (int k = 0; k < NUM_PORTS; k++)
            if (wr_en && addr == ADDR_W'(EN_BASE + k))
               en_q[k*BYTE_W +: BYTE_W] <= wr_data;
         for (int j = 0; j < POL_REGS; j++)
            if (wr_en && addr == ADDR_W'(POL_BASE + j))
               pol_q[j*BYTE_W +: BYTE_W] <= wr_data;
         if (ctl_wr) ien_q <= wr_data[CTL_IEN];
      end
   end

   evs_edge_detect #(.NUM_CH(NUM_CH), .GROUP_W(GROUP_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .in_lvl(in_lvl), .pol(pol_q), .en(en_q), .hit(hit)
   );

   evs_status_latch #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst_n(rst_n), .srst(srst), .set(hit), .clr(clr), .en(en_q), .stat(stat)
   );

   evs_port_summary #(.NUM_CH(NUM_CH)) u_sum (
      .stat(stat), .summary(summary)
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         if (addr == ADDR_W'(EN_BASE + k))   rd_data = en_q[k*BYTE_W +: BYTE_W];
         if (addr == ADDR_W'(STAT_BASE + k)) rd_data = stat[k*BYTE_W +: BYTE_W];
      end
      for (int j = 0; j < POL_REGS; j++)
         if (addr == ADDR_W'(POL_BASE + j)) rd_data = pol_q[j*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(SUM_ADDR)) rd_data = summary;
      if (addr == ADDR_W'(CTL_ADDR)) rd_data = {{(BYTE_W-1){1'b0}}, ien_q};
   end

   assign irq_n = ~(ien_q & (|stat));

   // R3: soft reset leaves enables and polarities at zero
   assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (en_q == '0 && pol_q == '0));

   // R8: soft reset keeps the interrupt enable
   assert_srst_keeps_ien_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> $stable(ien_q));

   // R4: no request while globally disabled
   assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_q |-> irq_n);

   // R4: pending summary with enable drives the request
   assert_irq_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q && summary[SUM_FLAG]) |-> !irq_n);

   // R9: the global flag tracks the port bits
   assert_summary_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      summary[SUM_FLAG] == (|summary[NUM_PORTS-1:0]));
endmodule

// File: tb/evs_unit_bench.sv
module evs_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_lvl = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evs_unit u_evs_unit (
      .clk(clk), .rst_n(rst_n), .in_lvl(in_lvl), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic set_in(input logic [31:0] v);
      @(negedge clk);
      in_lvl = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 11; a++) chk_reg("R3 reset register", 4'(a), 8'h00);
      chk("R8 reset irq_n", irq_n, 1'b1);
   endtask

   task automatic t_rise;
      wr(0, 8'h01);
      wr(10, 8'h01);
      chk_reg("R1 enable readback", 0, 8'h01);
      set_in(32'h1);
      chk_reg("R1 rise latched", 5, 8'h01);
      chk("R4 irq asserted", irq_n, 1'b0);
      chk_reg("R9 summary one port", 9, 8'h81);
      wr(5, 8'h00);
      chk_reg("R6 write zero keeps", 5, 8'h01);
      wr(5, 8'h01);
      chk_reg("R6 w1c clears", 5, 8'h00);
      repeat (3) @(negedge clk);
      chk_reg("R11 steady level", 5, 8'h00);
      chk("R11 irq released", irq_n, 1'b1);
   endtask

   task automatic t_fall;
      wr(4, 8'h02);
      wr(0, 8'h30);
      chk_reg("R2 polarity readback", 4, 8'h02);
      set_in(32'h11);
      chk_reg("R2 rise ignored on negative group", 5, 8'h00);
      set_in(32'h01);
      chk_reg("R2 fall latched", 5, 8'h10);
   endtask

   task automatic t_disabled;
      set_in(32'h41);
      set_in(32'h01);
      chk_reg("R5 disabled ch6", 5, 8'h10);
      set_in(32'h10001);
      set_in(32'h00001);
      chk_reg("R5 disabled ch16", 7, 8'h00);
      wr(2, 8'h02);
      set_in(32'h20001);
      chk_reg("R1 port2 rise", 7, 8'h02);
      chk_reg("R9 summary two ports", 9, 8'h85);
   endtask

   task automatic t_irq_gate;
      wr(10, 8'h00);
      chk("R4 irq gated off", irq_n, 1'b1);
      chk_reg("R4 status kept while gated", 7, 8'h02);
      wr(10, 8'h01);
      chk("R4 irq regated on", irq_n, 1'b0);
      wr(5, 8'hFF);
      wr(7, 8'hFF);
      chk("R4 irq after clear", irq_n, 1'b1);
      chk_reg("R9 summary empty", 9, 8'h00);
   endtask

   task automatic t_collision;
      wr(0, 8'h01);
      set_in(32'h20000);
      set_in(32'h20001);
      chk_reg("R7 pre-set", 5, 8'h01);
      set_in(32'h20000);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'd5; wr_data = 8'h01; in_lvl = 32'h20001;
      @(negedge clk);
      wr_en = 1'b0;
      chk_reg("R7 clear vs event", 5, 8'h01);
      wr(5, 8'h01);
      chk_reg("R6 clear after collision", 5, 8'h00);
   endtask

   task automatic t_cos;
      wr(0, 8'h00);
      wr(2, 8'h00);
      wr(1, 8'h11);
      wr(4, 8'h08);
      set_in(32'h20000);
      set_in(32'h21100);
      chk_reg("R10 rise detector", 6, 8'h01);
      wr(6, 8'hFF);
      set_in(32'h20000);
      chk_reg("R10 fall detector", 6, 8'h10);
      chk("R4 irq on cos", irq_n, 1'b0);
   endtask

   task automatic t_soft;
      wr(10, 8'h02);
      chk_reg("R3 soft enables", 1, 8'h00);
      chk_reg("R3 soft polarity", 4, 8'h00);
      chk_reg("R3 soft status", 6, 8'h00);
      chk_reg("R8 enable kept", 10, 8'h01);
      chk("R3 irq after soft", irq_n, 1'b1);
      set_in(32'h21100);
      chk_reg("R3 channel off after soft", 6, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rise();
      t_fall();
      t_disabled();
      t_irq_gate();
      t_collision();
      t_cos();
      t_soft();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): got hang expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule